// File: doc/BRIEF.md
# Memory-Side Reordering Command Queue

This block sits at the memory end of a host link. It takes memory commands one per cycle, holds them in a slot queue, and issues them to a memory back end in an order chosen to cut average latency rather than in arrival order. Each command carries an opcode, a 128-bit address, write data, a transaction ID and three tag bits: non-queuable, lock and coherency-member. Writes are posted. Reads and read-modify-writes (RMW) get a response that carries the originating transaction ID, so the host can match completions that come back out of order.

The usable queue depth is set at run time through `cfg_depth`. The scheduler picks at most one command per cycle. It honours bank readiness, same-address write ordering, strict arrival order for non-queuable commands, one atomic (locked) operation in flight at a time, a priority class for coherency-member RMWs, and a starvation limit that protects the oldest entry. The back end returns read data in issue order, and the block pairs each return with its stored ID.

Top module: `rq_reorder_queue`

## Requirements
- R1: `in_ready` is high exactly when occupancy is below the effective limit. The limit is `cfg_depth`, with 0 treated as 1 and any value above SLOTS (default 16) treated as SLOTS. A command is taken on a cycle with `in_valid` and `in_ready` both high.
- R2: At most one command issues per cycle, as a one-cycle `iss_valid` pulse. A command issues only while its bank is ready. The bank is address bits [7:6] and indexes `bank_ready`.
- R3: Eligible commands issue in three classes, and the lowest class present wins. Class 0 is an RMW (op 4) with the coherency tag set. Class 1 is any other non-queued opcode: read 0, write 1, RMW 4, internal 5. Class 2 is the queued opcodes: read-queued 2, write-queued 3. Within a class the oldest command issues first.
- R4: No command issues while an older pending command to the same address is write-type (op 1, 3 or 4).
- R5: While any pending command has the non-queuable tag, only the oldest pending command may issue.
- R6: A locked command issues only when no lock is in flight. Its issue puts a lock in flight on its address. Until an `unlock` pulse, any command to that address and any other locked command is held.
- R7: After 16 consecutive issues that bypass the oldest pending command, only the oldest may issue.
- R8: Each read (op 0 or 2) and RMW yields one response. The response comes one cycle after the back end's `be_rvalid`, carries `be_rdata` and the command's ID, and responses arrive in issue order. Writes and internal commands yield no response.
- R9: After reset the queue is empty, no lock is in flight, and `iss_valid` and `rsp_valid` are low.
- R10: An issued command presents its opcode, address, write data, ID and lock tag unchanged from its arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 9 | Run-time queue depth limit (1..256) |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Queue can take a command |
| in_op | input | 3 | Opcode |
| in_addr | input | 128 | Command address |
| in_wdata | input | 64 | Write data |
| in_id | input | 8 | Transaction ID |
| in_noq | input | 1 | Non-queuable tag |
| in_lock | input | 1 | Lock (atomic) tag |
| in_coh | input | 1 | Source is a coherency-domain member |
| bank_ready | input | 4 | Per-bank ready from back end |
| unlock | input | 1 | Releases the lock in flight |
| iss_valid | output | 1 | Issue pulse |
| iss_op | output | 3 | Issued opcode |
| iss_addr | output | 128 | Issued address |
| iss_wdata | output | 64 | Issued write data |
| iss_id | output | 8 | Issued transaction ID |
| iss_lock | output | 1 | Issued lock tag |
| be_rvalid | input | 1 | Back end returns read data |
| be_rdata | input | 64 | Returned data |
| rsp_valid | output | 1 | Response to host |
| rsp_id | output | 8 | Response transaction ID |
| rsp_data | output | 64 | Response data |

## Verification
A command taken at one clock edge can issue at the next edge at the earliest, because the pick is combinational from the stored queue and the issue fields are registered. A response appears one edge after `be_rvalid`. The bench does not tie checks to absolute cycles. It holds all banks not ready while it loads a scenario, then releases them, and a monitor compares every issue pulse and every response at the falling edge against queued expectations in order. Any extra, missing or reordered item shows up as a mismatch. Waits that must show nothing issuing, such as a held same-address read or a lock-blocked read, are covered the same way: an early issue takes the place of the expected ID.

// File: rtl/rq_pkg.sv
package rq_pkg;
    localparam int ADDR_W = 128;
    localparam int DATA_W = 64;
    localparam int ID_W   = 8;

    typedef enum logic [2:0] {
        OP_RD  = 3'd0,
        OP_WR  = 3'd1,
        OP_RDQ = 3'd2,
        OP_WRQ = 3'd3,
        OP_RMW = 3'd4,
        OP_INT = 3'd5
    } rq_op_e;

    typedef struct packed {
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [ID_W-1:0]   id;
        logic              noq;
        logic              lock;
        logic              coh;
    } rq_entry_t;

    function automatic logic op_writes(input logic [2:0] op);
        return (op == 3'(OP_WR)) || (op == 3'(OP_WRQ)) || (op == 3'(OP_RMW));
    endfunction

    function automatic logic op_returns(input logic [2:0] op);
        return (op == 3'(OP_RD)) || (op == 3'(OP_RDQ)) || (op == 3'(OP_RMW));
    endfunction

    function automatic logic op_queued(input logic [2:0] op);
        return (op == 3'(OP_RDQ)) || (op == 3'(OP_WRQ));
    endfunction
endpackage

// File: rtl/rq_tag_fifo.sv
module rq_tag_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_id,
    input  logic         pop,
    output logic [W-1:0] head_id,
    output logic         space
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_id;
            st_d.wp = bump(st_q.wp);
        end
        if (pop) st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_id = st_q.mem[st_q.rp];
    assign space   = (st_q.cnt < CNT_W'(DEPTH));

    // R8: a returned read must match an outstanding ID
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));
    // R8: never more outstanding IDs than storage
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.cnt < CNT_W'(DEPTH)));
endmodule

// File: rtl/rq_pick.sv
module rq_pick
    import rq_pkg::*;
#(
    parameter int SLOTS    = 16,
    parameter int NBANK    = 4,
    parameter int BANK_LSB = 6
) (
    input  logic [SLOTS-1:0]             vld,
    input  logic [SLOTS-1:0][2:0]        op,
    input  logic [SLOTS-1:0][ADDR_W-1:0] addr,
    input  logic [SLOTS-1:0]             noq,
    input  logic [SLOTS-1:0]             lock,
    input  logic [SLOTS-1:0]             coh,
    input  logic [NBANK-1:0]             bank_ready,
    input  logic                         lock_busy,
    input  logic [ADDR_W-1:0]            lock_addr,
    input  logic                         rsp_space,
    input  logic                         force_head,
    output logic                         pick_valid,
    output logic [$clog2(SLOTS)-1:0]     pick_idx,
    output logic                         any_noq
);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [SLOTS-1:0] hazard, ok, cls0, cls1, cls2;
    logic             head_only;

    function automatic logic [IDX_W-1:0] first_set(input logic [SLOTS-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    assign any_noq   = |(vld & noq);
    assign head_only = any_noq | force_head;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            hazard[i] = 1'b0;
            for (int j = 0; j < SLOTS; j++) begin
                if (j < i && vld[j] && op_writes(op[j]) && addr[j] == addr[i])
                    hazard[i] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic bank_ok, lock_hold, rsp_hold;
        assign bank_ok   = bank_ready[addr[g][BANK_LSB +: BANK_W]];
        assign lock_hold = lock_busy && (lock[g] || addr[g] == lock_addr);
        assign rsp_hold  = op_returns(op[g]) && !rsp_space;
        assign ok[g]     = vld[g] && bank_ok && !lock_hold && !rsp_hold && !hazard[g]
                           && ((g == 0) || !head_only);
        assign cls0[g]   = ok[g] && (op[g] == 3'(OP_RMW)) && coh[g];
        assign cls1[g]   = ok[g] && !op_queued(op[g]) && !cls0[g];
        assign cls2[g]   = ok[g] && op_queued(op[g]);
    end

    always_comb begin
        pick_valid = |ok;
        if (|cls0)      pick_idx = first_set(cls0);
        else if (|cls1) pick_idx = first_set(cls1);
        else            pick_idx = first_set(cls2);
    end
endmodule

// File: rtl/rq_reorder_queue.sv
module rq_reorder_queue
    import rq_pkg::*;
#(
    parameter int SLOTS     = 16,
    parameter int NBANK     = 4,
    parameter int BANK_LSB  = 6,
    parameter int STARVE    = 16,
    parameter int RSP_DEPTH = 8,
    parameter int CFG_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_depth,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [ID_W-1:0]   in_id,
    input  logic              in_noq,
    input  logic              in_lock,
    input  logic              in_coh,
    input  logic [NBANK-1:0]  bank_ready,
    input  logic              unlock,
    output logic              iss_valid,
    output logic [2:0]        iss_op,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [DATA_W-1:0] iss_wdata,
    output logic [ID_W-1:0]   iss_id,
    output logic              iss_lock,
    input  logic              be_rvalid,
    input  logic [DATA_W-1:0] be_rdata,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int ST_W  = $clog2(STARVE + 1);

    typedef struct packed {
        rq_entry_t [SLOTS-1:0] ents;
        logic [SLOTS-1:0]      vld;
        logic [CNT_W-1:0]      cnt;
        logic [ST_W-1:0]       starve;
        logic                  lock_busy;
        logic [ADDR_W-1:0]     lock_addr;
        logic                  iss_valid;
        logic [2:0]            iss_op;
        logic [ADDR_W-1:0]     iss_addr;
        logic [DATA_W-1:0]     iss_wdata;
        logic [ID_W-1:0]       iss_id;
        logic                  iss_lock;
        logic                  rsp_valid;
        logic [ID_W-1:0]       rsp_id;
        logic [DATA_W-1:0]     rsp_data;
    } st_t;

    st_t st_d, st_q;

    logic [SLOTS-1:0][2:0]        a_op;
    logic [SLOTS-1:0][ADDR_W-1:0] a_addr;
    logic [SLOTS-1:0]             a_noq, a_lock, a_coh;
    logic                         pick_valid, any_noq, force_head, rsp_space;
    logic [IDX_W-1:0]             pick_idx;
    logic [ID_W-1:0]              head_id;
    logic [CFG_W-1:0]             lim;
    logic                         take;
    rq_entry_t                    chosen, incoming;
    logic [CNT_W-1:0]             ins;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            a_op[i]   = st_q.ents[i].op;
            a_addr[i] = st_q.ents[i].addr;
            a_noq[i]  = st_q.ents[i].noq;
            a_lock[i] = st_q.ents[i].lock;
            a_coh[i]  = st_q.ents[i].coh;
        end
    end

    assign force_head = (st_q.starve == ST_W'(STARVE));

    rq_pick #(.SLOTS(SLOTS), .NBANK(NBANK), .BANK_LSB(BANK_LSB)) u_pick (
        .vld(st_q.vld), .op(a_op), .addr(a_addr), .noq(a_noq), .lock(a_lock),
        .coh(a_coh), .bank_ready(bank_ready), .lock_busy(st_q.lock_busy),
        .lock_addr(st_q.lock_addr), .rsp_space(rsp_space), .force_head(force_head),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .any_noq(any_noq)
    );

    assign chosen = st_q.ents[pick_idx];

    rq_tag_fifo #(.DEPTH(RSP_DEPTH), .W(ID_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .push(pick_valid && op_returns(chosen.op)), .push_id(chosen.id),
        .pop(be_rvalid), .head_id(head_id), .space(rsp_space)
    );

    always_comb begin
        if (cfg_depth == '0)                 lim = CFG_W'(1);
        else if (cfg_depth > CFG_W'(SLOTS)) lim = CFG_W'(SLOTS);
        else                                 lim = cfg_depth;
    end

    assign in_ready = (CFG_W'(st_q.cnt) < lim);
    assign take     = in_valid && in_ready;
    assign incoming = '{op: in_op, addr: in_addr, wdata: in_wdata, id: in_id,
                        noq: in_noq, lock: in_lock, coh: in_coh};
    assign ins      = st_q.cnt - (pick_valid ? CNT_W'(1) : CNT_W'(0));

    always_comb begin
        st_d = st_q;
        st_d.iss_valid = 1'b0;
        if (pick_valid) begin
            st_d.iss_valid = 1'b1;
            st_d.iss_op    = chosen.op;
            st_d.iss_addr  = chosen.addr;
            st_d.iss_wdata = chosen.wdata;
            st_d.iss_id    = chosen.id;
            st_d.iss_lock  = chosen.lock;
            for (int i = 0; i < SLOTS - 1; i++) begin
                if (i >= int'(pick_idx)) begin
                    st_d.ents[i] = st_q.ents[i+1];
                    st_d.vld[i]  = st_q.vld[i+1];
                end
            end
            st_d.vld[SLOTS-1] = 1'b0;
        end
        if (take) st_d.ents[IDX_W'(ins)] = incoming;
        if (take) st_d.vld[IDX_W'(ins)]  = 1'b1;
        st_d.cnt = ins + (take ? CNT_W'(1) : CNT_W'(0));
        if (!pick_valid) st_d.cnt = st_q.cnt + (take ? CNT_W'(1) : CNT_W'(0));

        if (!st_q.vld[0])
            st_d.starve = '0;
        else if (pick_valid) begin
            if (pick_idx == '0)                       st_d.starve = '0;
            else if (st_q.starve != ST_W'(STARVE))    st_d.starve = st_q.starve + 1'b1;
        end

        if (unlock) st_d.lock_busy = 1'b0;
        if (pick_valid && chosen.lock) begin
            st_d.lock_busy = 1'b1;
            st_d.lock_addr = chosen.addr;
        end

        st_d.rsp_valid = be_rvalid;
        st_d.rsp_id    = head_id;
        st_d.rsp_data  = be_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_valid = st_q.iss_valid;
    assign iss_op    = st_q.iss_op;
    assign iss_addr  = st_q.iss_addr;
    assign iss_wdata = st_q.iss_wdata;
    assign iss_id    = st_q.iss_id;
    assign iss_lock  = st_q.iss_lock;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_id    = st_q.rsp_id;
    assign rsp_data  = st_q.rsp_data;

    // R1: an accepted command never pushes occupancy past the limit of that cycle
    assert_depth_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take) |-> (CFG_W'(st_q.cnt) <= $past(lim)));
    // R1: occupied slots stay packed at the low end and match the count
    assert_packed_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vld) == int'(st_q.cnt));
    // R5: with a non-queuable entry pending, only the head leaves
    assert_strict_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_noq && pick_valid) |-> (pick_idx == '0));
    // R6: issued command never targets the address under a lock in flight
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && $past(st_q.lock_busy)) |-> (iss_addr != $past(st_q.lock_addr) && !iss_lock));
    // R7: starvation bound forces the head
    assert_starve_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_head && pick_valid) |-> (pick_idx == '0));
    // R9: issue and response are quiet on the first cycle out of reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !$past(rst_n) |-> (!iss_valid && !rsp_valid));
endmodule

// File: tb/tb_rq_reorder_queue.sv
module tb_rq_reorder_queue;
    import rq_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [8:0]        cfg_depth = 9'd4;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [2:0]        in_op = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_wdata = '0;
    logic [ID_W-1:0]   in_id = '0;
    logic              in_noq = 1'b0, in_lock = 1'b0, in_coh = 1'b0;
    logic [3:0]        bank_ready = '0;
    logic              unlock = 1'b0;
    logic              iss_valid, iss_lock, rsp_valid;
    logic [2:0]        iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic [DATA_W-1:0] iss_wdata, rsp_data;
    logic [ID_W-1:0]   iss_id, rsp_id;
    logic              be_rvalid = 1'b0;
    logic [DATA_W-1:0] be_rdata = '0;

    int checks = 0, failures = 0;
    string cur_req = "R9";
    logic [7:0] exp_iss[$];
    logic [7:0] exp_rsp[$];
    logic [7:0] be_q[$];
    logic [2:0]        op_of[256];
    logic [ADDR_W-1:0] addr_of[256];
    logic              lock_of[256];

    rq_reorder_queue dut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .in_valid(in_valid),
        .in_ready(in_ready), .in_op(in_op), .in_addr(in_addr), .in_wdata(in_wdata),
        .in_id(in_id), .in_noq(in_noq), .in_lock(in_lock), .in_coh(in_coh),
        .bank_ready(bank_ready), .unlock(unlock), .iss_valid(iss_valid),
        .iss_op(iss_op), .iss_addr(iss_addr), .iss_wdata(iss_wdata), .iss_id(iss_id),
        .iss_lock(iss_lock), .be_rvalid(be_rvalid), .be_rdata(be_rdata),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int bank);
        return (ADDR_W'(tag) << 16) | (ADDR_W'(bank) << 6);
    endfunction

    function automatic logic ret_op(input logic [2:0] op);
        return op == 3'd0 || op == 3'd2 || op == 3'd4;
    endfunction

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic send(input logic [2:0] op, input int id, input logic [ADDR_W-1:0] a,
                        input logic noq, input logic lk, input logic coh);
        op_of[id] = op; addr_of[id] = a; lock_of[id] = lk;
        in_valid = 1'b1; in_op = op; in_addr = a; in_wdata = {8{8'(id)}};
        in_id = 8'(id); in_noq = noq; in_lock = lk; in_coh = coh;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_noq = 1'b0; in_lock = 1'b0; in_coh = 1'b0;
    endtask

    task automatic expect_iss(input int id);
        exp_iss.push_back(8'(id));
    endtask

    task automatic drain();
        int n = 0;
        while (exp_iss.size() != 0 && n < 400) begin @(negedge clk); n++; end
        repeat (6) @(negedge clk);
        chk(exp_iss.size() == 0, cur_req, "pending expected issues", exp_iss.size(), 0);
        bank_ready = '0;
        @(negedge clk);
    endtask

    // monitor: compares issue pulses and responses at the falling edge
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (exp_iss.size() == 0) begin
                chk(1'b0, cur_req, "unexpected issue id", iss_id, 0);
            end else begin
                logic [7:0] e;
                e = exp_iss.pop_front();
                chk(iss_id == e, cur_req, "issue order id", iss_id, e);
                chk(iss_op == op_of[e] && iss_addr == addr_of[e] && iss_lock == lock_of[e],
                    "R10", "issue fields", {iss_op, iss_lock, iss_addr[31:0]},
                    {op_of[e], lock_of[e], addr_of[e][31:0]});
                if (iss_op == 3'd1 || iss_op == 3'd3 || iss_op == 3'd4)
                    chk(iss_wdata == {8{e}}, "R10", "issue wdata", iss_wdata, {8{e}});
                if (ret_op(op_of[e])) exp_rsp.push_back(e);
            end
        end
        if (rst_n && rsp_valid) begin
            if (exp_rsp.size() == 0) begin
                chk(1'b0, "R8", "unexpected response id", rsp_id, 0);
            end else begin
                logic [7:0] r;
                r = exp_rsp.pop_front();
                chk(rsp_id == r && rsp_data == {8{r}}, "R8", "response id/data",
                    {rsp_id, rsp_data}, {r, {8{r}}});
            end
        end
    end

    // back end model: returns read data in issue order, one per cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            be_rvalid = 1'b0;
        end else begin
            if (iss_valid && ret_op(iss_op)) be_q.push_back(iss_id);
            if (be_q.size() != 0) begin
                logic [7:0] b;
                b = be_q.pop_front();
                be_rvalid = 1'b1; be_rdata = {8{b}};
            end else begin
                be_rvalid = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R9";
        chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
        chk(iss_valid == 1'b0, "R9", "iss_valid after reset", iss_valid, 0);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);

        // R1: limit of three, then zero treated as one
        cur_req = "R1";
        cfg_depth = 9'd3; @(negedge clk);
        send(3'd2, 60, mk_addr(60, 0), 0, 0, 0);
        send(3'd2, 61, mk_addr(61, 1), 0, 0, 0);
        chk(in_ready == 1'b1, "R1", "ready below limit", in_ready, 1);
        send(3'd2, 62, mk_addr(62, 2), 0, 0, 0);
        idle_in();
        chk(in_ready == 1'b0, "R1", "ready at limit 3", in_ready, 0);
        expect_iss(60); expect_iss(61); expect_iss(62);
        bank_ready = '1; drain();
        cfg_depth = 9'd0; @(negedge clk);
        send(3'd2, 63, mk_addr(63, 1), 0, 0, 0);
        idle_in();
        chk(in_ready == 1'b0, "R1", "ready with depth 0 (limit 1)", in_ready, 0);
        expect_iss(63);
        bank_ready = '1; drain();
        cfg_depth = 9'd16; @(negedge clk);

        // R2: only the ready bank issues
        cur_req = "R2";
        send(3'd2, 1, mk_addr(1, 0), 0, 0, 0);
        send(3'd2, 2, mk_addr(2, 1), 0, 0, 0);
        idle_in();
        expect_iss(2); expect_iss(1);
        bank_ready = 4'b0010;
        repeat (6) @(negedge clk);
        chk(exp_iss.size() == 1, "R2", "bank 0 held while not ready", exp_iss.size(), 1);
        bank_ready = '1; drain();

        // R3: class priority, oldest first in class; writes get no response (R8)
        cur_req = "R3";
        send(3'd2, 10, mk_addr(10, 0), 0, 0, 0);
        send(3'd3, 11, mk_addr(11, 1), 0, 0, 0);
        send(3'd0, 12, mk_addr(12, 2), 0, 0, 0);
        send(3'd4, 13, mk_addr(13, 3), 0, 0, 0);
        send(3'd4, 14, mk_addr(14, 0), 0, 0, 1);
        send(3'd1, 15, mk_addr(15, 1), 0, 0, 0);
        send(3'd5, 16, mk_addr(16, 2), 0, 0, 0);
        idle_in();
        expect_iss(14); expect_iss(12); expect_iss(13); expect_iss(15);
        expect_iss(16); expect_iss(10); expect_iss(11);
        bank_ready = '1; drain();

        // R4: read must wait behind older write to the same address
        cur_req = "R4";
        send(3'd3, 20, mk_addr(20, 0), 0, 0, 0);
        send(3'd0, 21, mk_addr(20, 0), 0, 0, 0);
        idle_in();
        expect_iss(20); expect_iss(21);
        bank_ready = '1; drain();

        // R5: non-queuable entry forces arrival order
        cur_req = "R5";
        send(3'd2, 30, mk_addr(30, 0), 0, 0, 0);
        send(3'd0, 31, mk_addr(31, 1), 1, 0, 0);
        send(3'd0, 32, mk_addr(32, 1), 0, 0, 0);
        idle_in();
        expect_iss(30); expect_iss(31); expect_iss(32);
        bank_ready = '1; drain();

        // R6: lock holds same-address command until unlock
        cur_req = "R6";
        send(3'd0, 40, mk_addr(40, 0), 0, 1, 0);
        send(3'd2, 41, mk_addr(40, 0), 0, 0, 0);
        send(3'd2, 42, mk_addr(42, 1), 0, 0, 0);
        send(3'd2, 43, mk_addr(43, 2), 0, 1, 0);
        idle_in();
        expect_iss(40); expect_iss(42);
        bank_ready = '1;
        repeat (10) @(negedge clk);
        chk(exp_iss.size() == 0, "R6", "issues before unlock", exp_iss.size(), 0);
        expect_iss(41); expect_iss(43);
        unlock = 1'b1; @(negedge clk); unlock = 1'b0;
        repeat (8) @(negedge clk);
        unlock = 1'b1; @(negedge clk); unlock = 1'b0;
        drain();

        // R7: oldest queued read bypassed at most 16 times; depth 256 clamps to 16 (R1)
        cur_req = "R7";
        cfg_depth = 9'd256; @(negedge clk);
        send(3'd2, 50, mk_addr(50, 0), 0, 0, 0);
        for (int k = 51; k <= 65; k++) send(3'd0, k, mk_addr(k, k % 4), 0, 0, 0);
        idle_in();
        chk(in_ready == 1'b0, "R1", "ready at clamped limit 16", in_ready, 0);
        for (int k = 51; k <= 66; k++) expect_iss(k);
        expect_iss(50);
        for (int k = 67; k <= 75; k++) expect_iss(k);
        bank_ready = '1;
        for (int k = 66; k <= 75; k++) send(3'd0, k, mk_addr(k, k % 4), 0, 0, 0);
        idle_in();
        drain();

        repeat (10) @(negedge clk);
        chk(exp_rsp.size() == 0, "R8", "responses still owed", exp_rsp.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule